// File: doc/BRIEF.md
# Dual-Channel Pointer-Addressed Register Front End

This block is the bus-side register front end of a two-channel serial controller. Each channel holds sixteen 8-bit write registers and a small set of read registers. A host reaches them over a simple byte bus that exposes only two ports per channel: a control port and a data port. The data port moves transmit and receive bytes directly. Every other register is reached indirectly. A control write made while the channel's pointer is zero loads the pointer, and the next control access (read or write) goes to the register the pointer names. The pointer then falls back to zero.

The block decodes the bus address into channel and port. It keeps both channels' register files and applies the power-on and software reset values. It gates transmit bytes on the transmit enable bit and accepts received bytes into a one-byte hold with an availability flag. A receive break sets a status bit. All write registers are exported as a flat vector for the serializer and baud logic. Software resets are issued by writing the reset field of register 9 from either channel. They can clear channel A, channel B or both.

Top module: `duo_chan_regbank`

## Requirements
- R1: Address bit ADDR_SHIFT selects the control port (0) or the data port (1), and address bit ADDR_SHIFT+1 selects the channel (0 = channel B, 1 = channel A). An access touches only the selected channel.
- R2: A control write while the pointer is 0 loads the pointer from write data bits 2:0. When the command field (bits 5:3) equals 1, 8 is added, reaching registers 8 to 15. Other command values leave the pointer at bits 2:0.
- R3: A control read or write made while the pointer is nonzero accesses the pointed register. After it, the pointer is 0, so the next control read returns status register 0.
- R4: Writing register 9 from either channel with bits 7:6 = 01 resets channel B, 10 resets channel A and 11 resets both. With 00 nothing is reset and the value is stored. A channel that is reset takes its reset values even if it is the one written.
- R5: After hardware reset or software reset, a channel's write registers are 4 = 0x04, 9 = 0xC0, 11 = 0x08, 14 = 0x30, 15 = 0xF8 and all others 0. Status register 0 reads 0x44 (bit 2 transmit empty, bit 6 underrun). Read register 1 reads 0x07. The pointer is 0, and the held receive byte and its flag are cleared.
- R6: A data-port write raises tx_valid for that channel for exactly one cycle, with tx_data equal to the written byte, but only when write register 5 bit 3 is set. When it does, status bit 2 and read register 1 bit 0 are set. Without the enable no tx_valid pulse appears.
- R7: A received byte (rx_valid) is accepted only when write register 3 bit 0 is set and status bit 0 is clear. Acceptance sets status bit 0. rx_ready shows exactly that acceptance condition.
- R8: A byte offered while status bit 0 is set, or while receive is disabled, is dropped, and the held byte is unchanged.
- R9: A data-port read returns the held byte and clears status bit 0.
- R10: A break input sets status bit 7 of its own channel only.
- R11: Reading read registers 2 to 15 returns 0.
- R12: wreg_out carries channel c register r at bits [(c*16+r)*8 +: 8], with c = 0 for channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (port and channel bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe |
| tx_valid | output | 2 | Per-channel transmit byte pulse (bit 0 = B, bit 1 = A) |
| tx_data | output | 16 | Transmit bytes (7:0 = B, 15:8 = A) |
| rx_valid | input | 2 | Per-channel received byte offer |
| rx_data | input | 16 | Received bytes (7:0 = B, 15:8 = A) |
| rx_ready | output | 2 | Per-channel receive acceptance condition |
| brk_in | input | 2 | Per-channel receive break indication |
| wreg_out | output | 256 | Both channels' write registers, flat |

## Verification
Pointer handling is tried with plain pointer loads, with the high-bank command and with a foreign command value. This tells an added offset apart from a merely copied field, and a returned pointer apart from a sticky one. The reset field is written with all four codes from both channels, and the untouched channel's registers are checked each time. A crossed or missing reset mask therefore shows up. Receive is driven with an accepted byte, a byte offered while one is held, and a byte offered to a disabled channel. This separates the drop rule from the accept rule. A break on one channel is checked against the other channel's status.

// File: rtl/duo_regs_pkg.sv
package duo_regs_pkg;

  localparam int BYTE_W   = 8;
  localparam int NREG     = 16;
  localparam int PTR_W    = $clog2(NREG);
  localparam int NCHAN    = 2;
  localparam int FILE_W   = NREG * BYTE_W;

  // write register indices with behaviour attached
  localparam int WR_RXCTL = 3;
  localparam int WR_TXCTL = 5;
  localparam int WR_MIC   = 9;

  // bit positions
  localparam int RXEN_BIT    = 0;
  localparam int TXEN_BIT    = 3;
  localparam int ST_RXAV     = 0;
  localparam int ST_TXEMPTY  = 2;
  localparam int ST_BRK      = 7;
  localparam int SP_ALLSENT  = 0;
  localparam int MIC_RST_LSB = 6;

  localparam logic [2:0] CMD_HIBANK = 3'd1;

  localparam logic [7:0] STAT_RST = 8'h44;
  localparam logic [7:0] SPEC_RST = 8'h07;

  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t wr_rst_val(input int unsigned idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/duo_addr_dec.sv
module duo_addr_dec
  import duo_regs_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int ADDR_SHIFT = 0
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NCHAN-1:0]  ctl_wr,
  output logic [NCHAN-1:0]  ctl_rd,
  output logic [NCHAN-1:0]  dat_wr,
  output logic [NCHAN-1:0]  dat_rd,
  output logic              rd_chan,
  output logic              rd_is_data
);

  localparam int PORT_BIT = ADDR_SHIFT;
  localparam int CHAN_BIT = ADDR_SHIFT + 1;

  logic is_data;
  assign is_data    = bus_addr[PORT_BIT];
  assign rd_chan    = bus_addr[CHAN_BIT];
  assign rd_is_data = is_data;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    logic hit;
    assign hit       = bus_sel && (bus_addr[CHAN_BIT] == 1'(c));
    assign ctl_wr[c] = hit &&  bus_wr && !is_data;
    assign ctl_rd[c] = hit && !bus_wr && !is_data;
    assign dat_wr[c] = hit &&  bus_wr &&  is_data;
    assign dat_rd[c] = hit && !bus_wr &&  is_data;
  end

endmodule

// File: rtl/duo_chan_file.sv
module duo_chan_file
  import duo_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  byte_t             wdata,
  input  logic              soft_rst,
  input  logic              rx_valid,
  input  byte_t             rx_byte,
  input  logic              brk,
  output byte_t             ctl_rdata,
  output byte_t             rx_hold,
  output logic              mic_wr,
  output logic              tx_valid,
  output byte_t             tx_data,
  output logic              rx_ready,
  output logic [FILE_W-1:0] wregs_flat
);

  byte_t            wreg_q [NREG];
  byte_t            wreg_d [NREG];
  logic [PTR_W-1:0] ptr_q, ptr_d;
  byte_t            stat_q, stat_d;
  byte_t            spec_q, spec_d;
  byte_t            rxb_q, rxb_d;
  logic             txv_q, txv_d;
  byte_t            txd_q, txd_d;

  logic ptr_home;
  logic rx_accept;
  logic tx_en;

  assign ptr_home  = (ptr_q == '0);
  assign tx_en     = wreg_q[WR_TXCTL][TXEN_BIT];
  assign rx_ready  = wreg_q[WR_RXCTL][RXEN_BIT] && !stat_q[ST_RXAV];
  assign rx_accept = rx_valid && rx_ready;
  assign mic_wr    = ctl_wr && (ptr_q == PTR_W'(WR_MIC));

  // next-state
  always_comb begin
    for (int r = 0; r < NREG; r++) wreg_d[r] = wreg_q[r];
    ptr_d  = ptr_q;
    stat_d = stat_q;
    spec_d = spec_q;
    rxb_d  = rxb_q;
    txv_d  = 1'b0;
    txd_d  = txd_q;

    if (ctl_wr) begin
      if (ptr_home) begin
        ptr_d = {(wdata[5:3] == CMD_HIBANK), wdata[2:0]};
      end else begin
        wreg_d[ptr_q] = wdata;
        ptr_d         = '0;
      end
    end

    if (ctl_rd && !ptr_home) ptr_d = '0;

    if (dat_wr && tx_en) begin
      txv_d              = 1'b1;
      txd_d              = wdata;
      stat_d[ST_TXEMPTY] = 1'b1;
      spec_d[SP_ALLSENT] = 1'b1;
    end

    if (dat_rd) stat_d[ST_RXAV] = 1'b0;

    if (rx_accept) begin
      rxb_d           = rx_byte;
      stat_d[ST_RXAV] = 1'b1;
    end

    if (brk) stat_d[ST_BRK] = 1'b1;

    if (soft_rst) begin
      for (int r = 0; r < NREG; r++) wreg_d[r] = wr_rst_val(r);
      ptr_d  = '0;
      stat_d = STAT_RST;
      spec_d = SPEC_RST;
      rxb_d  = '0;
      txv_d  = 1'b0;
      txd_d  = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) wreg_q[r] <= wr_rst_val(r);
      ptr_q  <= '0;
      stat_q <= STAT_RST;
      spec_q <= SPEC_RST;
      rxb_q  <= '0;
      txv_q  <= 1'b0;
      txd_q  <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) wreg_q[r] <= wreg_d[r];
      ptr_q  <= ptr_d;
      stat_q <= stat_d;
      spec_q <= spec_d;
      rxb_q  <= rxb_d;
      txv_q  <= txv_d;
      txd_q  <= txd_d;
    end
  end

  always_comb begin
    case (ptr_q)
      PTR_W'(0): ctl_rdata = stat_q;
      PTR_W'(1): ctl_rdata = spec_q;
      default:   ctl_rdata = '0;
    endcase
  end

  assign rx_hold  = rxb_q;
  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign wregs_flat[r*BYTE_W +: BYTE_W] = wreg_q[r];
  end

  AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_wr || ctl_rd) && !ptr_home) |=> (ptr_q == '0)); // R3

  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(dat_wr)); // R6

  AST_RX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !soft_rst) |=> stat_q[ST_RXAV]); // R7

  AST_RX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !soft_rst) |=> $stable(rxb_q)); // R8

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && !rx_valid && !soft_rst) |=> !stat_q[ST_RXAV]); // R9

  AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !soft_rst) |=> stat_q[ST_BRK]); // R10

endmodule

// File: rtl/duo_chan_regbank.sv
module duo_chan_regbank
  import duo_regs_pkg::*;
#(
  parameter int ADDR_SHIFT = 0,
  parameter int ADDR_W     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  output logic [NCHAN-1:0]          tx_valid,
  output logic [NCHAN*BYTE_W-1:0]   tx_data,
  input  logic [NCHAN-1:0]          rx_valid,
  input  logic [NCHAN*BYTE_W-1:0]   rx_data,
  output logic [NCHAN-1:0]          rx_ready,
  input  logic [NCHAN-1:0]          brk_in,
  output logic [NCHAN*FILE_W-1:0]   wreg_out
);

  localparam int CHAN_BIT = ADDR_SHIFT + 1;

  // reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [NCHAN-1:0] ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic             rd_chan, rd_is_data;

  duo_addr_dec #(
    .ADDR_W     (ADDR_W),
    .ADDR_SHIFT (ADDR_SHIFT)
  ) u_dec (
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ctl_wr     (ctl_wr),
    .ctl_rd     (ctl_rd),
    .dat_wr     (dat_wr),
    .dat_rd     (dat_rd),
    .rd_chan    (rd_chan),
    .rd_is_data (rd_is_data)
  );

  byte_t            ctl_rdata_v [NCHAN];
  byte_t            rx_hold_v   [NCHAN];
  logic [NCHAN-1:0] mic_wr;
  logic [NCHAN-1:0] soft_rst;

  // reset field of register 9, written from either channel; bit 6 -> B, bit 7 -> A
  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    assign soft_rst[c] = (|mic_wr) && bus_wdata[MIC_RST_LSB + c];

    duo_chan_file u_file (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .ctl_wr     (ctl_wr[c]),
      .ctl_rd     (ctl_rd[c]),
      .dat_wr     (dat_wr[c]),
      .dat_rd     (dat_rd[c]),
      .wdata      (bus_wdata),
      .soft_rst   (soft_rst[c]),
      .rx_valid   (rx_valid[c]),
      .rx_byte    (rx_data[c*BYTE_W +: BYTE_W]),
      .brk        (brk_in[c]),
      .ctl_rdata  (ctl_rdata_v[c]),
      .rx_hold    (rx_hold_v[c]),
      .mic_wr     (mic_wr[c]),
      .tx_valid   (tx_valid[c]),
      .tx_data    (tx_data[c*BYTE_W +: BYTE_W]),
      .rx_ready   (rx_ready[c]),
      .wregs_flat (wreg_out[c*FILE_W +: FILE_W])
    );

    AST_TX_CHAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
      tx_valid[c] |-> $past(bus_sel && bus_wr && bus_addr[ADDR_SHIFT]
                            && (bus_addr[CHAN_BIT] == 1'(c)))); // R1

    AST_SOFT_RST: assert property (@(posedge clk) disable iff (!rst_sync_n)
      soft_rst[c] |=> (wreg_out[(c*NREG + WR_MIC)*BYTE_W +: BYTE_W] == 8'hC0)); // R4
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      bus_rdata = rd_is_data ? rx_hold_v[rd_chan] : ctl_rdata_v[rd_chan];
    end
  end

endmodule

// File: tb/duo_chan_regbank_bench.sv
module duo_chan_regbank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SHIFT = 1;
  localparam int AW    = 3;
  localparam logic [7:0] CB = 8'd0, DB = 8'd2, CA = 8'd4, DA = 8'd6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [1:0]    tx_valid, rx_valid, rx_ready, brk_in;
  logic [15:0]   tx_data, rx_data;
  logic [255:0]  wreg_out;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duo_chan_regbank #(.ADDR_SHIFT(SHIFT), .ADDR_W(AW)) u_duo_chan_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .brk_in(brk_in),
    .wreg_out(wreg_out)
  );

  // {req, op, addr/-, arg/idx, expected}; op 1 write, 2 read, 3 wreg_out byte
  localparam int NV = 41;
  localparam logic [39:0] VEC [NV] = '{
    40'h05_02_04_00_44, // R5 A status
    40'h05_02_00_00_44, // R5 B status
    40'h02_01_04_01_00, // R2 pointer 1
    40'h05_02_04_00_07, // R5 read reg 1
    40'h03_02_04_00_44, // R3 pointer back home
    40'h02_01_04_02_00, // R2 pointer 2
    40'h0B_02_04_00_00, // R11 unmapped read
    40'h02_01_04_0D_00, // R2 high bank -> 13
    40'h02_01_04_5A_00, // R3 write reg 13
    40'h0C_03_00_1D_5A, // R12 A reg 13
    40'h02_01_04_13_00, // R2 other command, pointer 3
    40'h02_01_04_01_00, // R2 write A reg 3
    40'h02_03_00_13_01, // R2 R12 A reg 3
    40'h02_01_00_0E_00, // R2 B pointer 14
    40'h01_01_00_11_00, // R1 write B reg 14
    40'h01_03_00_0E_11, // R1 R12 B reg 14
    40'h05_03_00_04_04, // R5 B reg 4
    40'h05_03_00_09_C0, // R5 B reg 9
    40'h05_03_00_0B_08, // R5 B reg 11
    40'h05_03_00_0F_F8, // R5 B reg 15
    40'h05_03_00_1E_30, // R5 A reg 14
    40'h04_01_00_09_00, // R4 B pointer 9
    40'h04_01_00_40_00, // R4 reset B
    40'h04_03_00_0E_30, // R4 B reg 14 restored
    40'h04_03_00_1D_5A, // R4 A untouched
    40'h04_03_00_09_C0, // R4 B reg 9
    40'h04_01_04_09_00, // R4 A pointer 9
    40'h04_01_04_00_00, // R4 code 00 stores
    40'h04_03_00_19_00, // R4 A reg 9 stored
    40'h04_03_00_1D_5A, // R4 A still intact
    40'h04_01_00_09_00, // R4 B pointer 9
    40'h04_01_00_80_00, // R4 reset A from B
    40'h04_03_00_09_80, // R4 B stores value
    40'h04_03_00_1D_00, // R4 A reg 13 cleared
    40'h04_03_00_19_C0, // R4 A reg 9 reset
    40'h04_03_00_13_00, // R4 A reg 3 cleared
    40'h05_02_04_00_44, // R5 A status
    40'h04_01_04_09_00, // R4 A pointer 9
    40'h04_01_04_C0_00, // R4 reset both
    40'h04_03_00_09_C0, // R4 B reg 9
    40'h04_03_00_19_C0  // R4 A reg 9
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[AW-1:0];
    #1 q = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_pulse(input int ch, input logic [7:0] b);
    @(negedge clk);
    rx_valid[ch] = 1'b1; rx_data[ch*8 +: 8] = b;
    @(negedge clk);
    rx_valid = 2'b00;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_valid = '0; rx_data = '0; brk_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R5 tx_valid idle", {14'd0, tx_valid}, 16'd0);
    chk("R5 rx_ready idle", {14'd0, rx_ready}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] req, op, ad, arg, ex;
      {req, op, ad, arg, ex} = VEC[i];
      if (op == 8'd1) begin
        wr(ad, arg);
      end else if (op == 8'd2) begin
        rd(ad, q);
        chk($sformatf("R%0d row %0d", req, i), {8'd0, q}, {8'd0, ex});
      end else begin
        @(negedge clk);
        chk($sformatf("R%0d row %0d", req, i), {8'd0, wreg_out[arg*8 +: 8]}, {8'd0, ex});
      end
    end

    // transmit gating R6
    wr(CA, 8'h05); wr(CA, 8'h08);
    wr(DA, 8'h3C);
    chk("R6 tx pulse A", {14'd0, tx_valid}, 16'h0002);
    chk("R6 tx data A", {8'd0, tx_data[15:8]}, 16'h003C);
    @(negedge clk);
    chk("R6 tx single cycle", {14'd0, tx_valid}, 16'd0);
    wr(DB, 8'h77);
    chk("R6 tx blocked B", {14'd0, tx_valid}, 16'd0);
    rd(CA, q); chk("R6 status A", {8'd0, q}, 16'h0044);
    wr(CA, 8'h01); rd(CA, q); chk("R6 all-sent", {8'd0, q}, 16'h0007);

    // receive R7 R8 R9
    wr(CA, 8'h03); wr(CA, 8'h01);
    chk("R7 rx_ready A", {14'd0, rx_ready}, 16'h0002);
    rx_pulse(1, 8'hA5);
    rd(CA, q); chk("R7 rx avail", {8'd0, q}, 16'h0045);
    chk("R7 rx_ready drop", {14'd0, rx_ready}, 16'd0);
    rx_pulse(1, 8'h99);
    rd(DA, q); chk("R8 R9 held byte", {8'd0, q}, 16'h00A5);
    rd(CA, q); chk("R9 avail cleared", {8'd0, q}, 16'h0044);
    rx_pulse(0, 8'h12);
    rd(CB, q); chk("R8 B disabled status", {8'd0, q}, 16'h0044);
    rd(DB, q); chk("R8 B hold unchanged", {8'd0, q}, 16'h0000);

    // break R10
    @(negedge clk); brk_in = 2'b01; @(negedge clk); brk_in = 2'b00;
    rd(CB, q); chk("R10 break B", {8'd0, q}, 16'h00C4);
    rd(CA, q); chk("R10 A unaffected", {8'd0, q}, 16'h0044);
    wr(CB, 8'h09); wr(CB, 8'h40);
    rd(CB, q); chk("R4 R5 B after soft reset", {8'd0, q}, 16'h0044);

    // hardware reset mid-run R5
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R5 A reg 5 cleared", {8'd0, wreg_out[21*8 +: 8]}, 16'h0000);
    chk("R5 A reg 3 cleared", {8'd0, wreg_out[19*8 +: 8]}, 16'h0000);
    chk("R5 A reg 15", {8'd0, wreg_out[31*8 +: 8]}, 16'h00F8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule